// File: doc/BRIEF.md
# Cascadable Eight-Input Priority Interrupt Controller

This block collects up to eight interrupt requests, holds them in a request register, filters them through a mask register and resolves the most urgent one under a fixed priority scheme. Input 0 is the most urgent. The host reaches the block through a byte-wide register port with two addresses. Address 0 is a command port, which carries initialization, poll, read-select and end-of-interrupt codes. Address 1 is a data port for the mask and for the later initialization words. The single interrupt output is high whenever a request is ready to be serviced.

The host services interrupts by polling. It writes a poll command, and the next command-port read returns the winning level with a valid flag. That read also moves the level from the request register into the in-service register. A later end-of-interrupt command releases the level. Two instances can be chained into a 16-input system: the slave's interrupt output drives one input of the master, and that input is marked as a cascade input in the master's initialization.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the in-service and request registers are zero, command-port reads return the request register, and `irq_out` is low.
- R2: A command-port write with bit 4 set starts initialization. It clears the mask and the in-service register, selects the request register for reads, and takes bit 3 as the trigger mode (1 = level, 0 = edge). Up to three following data-port writes are then taken as initialization words and do not change the mask.
- R3: The number of initialization words depends on the first command byte. The cascade word is skipped when bit 1 is set, and the mode word is skipped when bit 0 is clear. The first data-port write after the last expected word loads the mask.
- R4: Outside initialization, a data-port write loads the mask and a data-port read returns it. A request on a masked input is still recorded in the request register but never raises `irq_out`.
- R5: In edge mode a request bit is set by a rising input and stays set only while the input stays high. An input held high after service does not request again. In level mode the request bit follows the input level.
- R6: `irq_out` is high exactly when some unmasked request exists at a level that has no in-service bit set at the same level or a more urgent one. Level 0 is the most urgent and level 7 the least.
- R7: Command byte 0x0B selects the in-service register for later command-port reads, and 0x0A selects the request register.
- R8: Command byte 0x0C makes the next command-port read a poll. It returns bit 7 = valid and bits 2:0 = the winning level. When valid, it sets that in-service bit and clears that request bit. With nothing eligible it returns 0x07.
- R9: Command byte 0x60 + n (n = 0..7) clears in-service bit n.
- R10: Command byte 0x20 clears the most urgent set in-service bit.
- R11: A level-7 edge request that disappears before the poll yields a poll result of 0x07 and leaves in-service bit 7 clear.
- R12: On a master (`master_sel` = 1), inputs whose bit is set in the cascade word are always level-sensitive. As a result, a slave that still requests after the master's end-of-interrupt raises the master again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_sel | input | 1 | 1 = acts as cascade master, 0 = slave or stand-alone |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a poll read takes effect on this cycle's edge) |
| bus_addr | input | 1 | 0 = command port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the current state |
| irq_in | input | 8 | Interrupt request inputs, bit 0 most urgent |
| irq_out | output | 1 | Interrupt request to the host or to a master |

## Verification
The resolver is driven with single requests, with two requests arriving together, and with a request more urgent than one already in service. These separate a plain priority encoder from one that also honours nesting. Edge and level trigger modes get the same held-high input after service: edge mode must stay quiet and level mode must request again. A request that vanishes before the poll tells proper spurious handling apart from a sticky latch. A two-device cascade, with the master released while the slave still requests, shows whether the cascade input is forced to level sensitivity.

// File: rtl/irq_prio_pkg.sv
// Package: shared sizes, command field helpers and the initialization
// sequencer state type for the priority interrupt controller.
package irq_prio_pkg;
    localparam int NUM_IN  = 8;
    localparam int LVL_W   = $clog2(NUM_IN);
    localparam int BYTE_W  = 8;

    // Initialization word sequencer states
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_BASE = 2'd1,
        SEQ_CASC = 2'd2,
        SEQ_MODE = 2'd3
    } seq_e;

    // Command-port opcode field values (bits 7:5) for end-of-interrupt
    localparam logic [2:0] OP_EOI_NS  = 3'b001;
    localparam logic [2:0] OP_EOI_SP  = 3'b011;
endpackage

// File: rtl/irq_init_seq.sv
// Module: irq_init_seq
// Tracks which initialization word the next data-port write carries.
// Assumes: start and data_wr are single-cycle strobes; start wins.
module irq_init_seq
    import irq_prio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic skip_casc,
    input  logic want_mode,
    input  logic data_wr,
    output logic busy,
    output logic casc_we
);
    seq_e state_q;
    logic skip_casc_q;
    logic want_mode_q;

    // Advance through the expected initialization words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SEQ_IDLE;
            skip_casc_q <= 1'b0;
            want_mode_q <= 1'b0;
        end else if (start) begin
            state_q     <= SEQ_BASE;
            skip_casc_q <= skip_casc;
            want_mode_q <= want_mode;
        end else if (data_wr) begin
            case (state_q)
                SEQ_BASE: state_q <= !skip_casc_q ? SEQ_CASC :
                                     (want_mode_q ? SEQ_MODE : SEQ_IDLE);
                SEQ_CASC: state_q <= want_mode_q ? SEQ_MODE : SEQ_IDLE;
                SEQ_MODE: state_q <= SEQ_IDLE;
                default:  state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Outputs: data port owned by the sequencer, cascade word strobe
    always_comb begin
        busy    = (state_q != SEQ_IDLE);
        casc_we = data_wr && (state_q == SEQ_CASC);
    end
endmodule

// File: rtl/irq_req_capture.sv
// Module: irq_req_capture
// Per-input request latch, edge or level sensitive per bit.
// Assumes: inputs are already synchronous to clk.
module irq_req_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_in,
    input  logic [N-1:0] level_sel,
    input  logic         clr_all,
    input  logic [N-1:0] svc_clr,
    output logic [N-1:0] irr
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Latch a request; drop it when the input falls or it is serviced
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[i] <= 1'b0;
                irr[i]    <= 1'b0;
            end else begin
                prev_q[i] <= req_in[i];
                if (clr_all || !req_in[i])
                    irr[i] <= 1'b0;
                else if (level_sel[i] || !prev_q[i])
                    irr[i] <= 1'b1;
                else if (svc_clr[i])
                    irr[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Module: irq_prio_pick
// Fixed-priority resolver: bit 0 most urgent. A request wins only if no
// in-service bit sits at its level or above. Also finds the top in-service bit.
module irq_prio_pick
    import irq_prio_pkg::*;
#(
    parameter int N = NUM_IN,
    localparam int LW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  isr,
    output logic          found,
    output logic [LW-1:0] lvl,
    output logic          top_found,
    output logic [LW-1:0] top_lvl
);
    // Scan from the most urgent level downwards
    always_comb begin
        logic stop;
        found     = 1'b0;
        lvl       = '0;
        top_found = 1'b0;
        top_lvl   = '0;
        stop      = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!stop) begin
                if (isr[i]) begin
                    stop      = 1'b1;
                    top_found = 1'b1;
                    top_lvl   = LW'(i);
                end else if (req[i]) begin
                    stop  = 1'b1;
                    found = 1'b1;
                    lvl   = LW'(i);
                end
            end
        end
        if (found) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (isr[i]) begin
                    top_found = 1'b1;
                    top_lvl   = LW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Module: irq_prio_ctrl (top)
// Eight-input priority interrupt controller with a command/data register
// port, poll-based service, specific and non-specific end of interrupt,
// and master/slave cascading. Assumes single-cycle bus strobes.
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [NUM_IN-1:0] irq_in,
    output logic              irq_out
);
    logic [NUM_IN-1:0] imr_q, isr_q, isr_d, irr, casc_q, level_sel, svc_clr;
    logic              sel_isr_q, poll_q, level_mode_q;
    logic              cmd_wr, dat_wr, init_wr, sel_wr, eoi_wr, spec_eoi, ns_eoi, poll_rd;
    logic              init_busy, casc_we;
    logic              found, top_found;
    logic [LVL_W-1:0]  lvl, top_lvl;

    // Command decode from the write byte
    always_comb begin
        cmd_wr   = bus_wr && !bus_addr;
        dat_wr   = bus_wr && bus_addr;
        init_wr  = cmd_wr && bus_wdata[4];
        sel_wr   = cmd_wr && !bus_wdata[4] && bus_wdata[3];
        eoi_wr   = cmd_wr && (bus_wdata[4:3] == 2'b00);
        spec_eoi = eoi_wr && (bus_wdata[7:5] == OP_EOI_SP);
        ns_eoi   = eoi_wr && (bus_wdata[7:5] == OP_EOI_NS);
        poll_rd  = bus_rd && !bus_addr && poll_q;
    end

    irq_init_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (init_wr),
        .skip_casc(bus_wdata[1]),
        .want_mode(bus_wdata[0]),
        .data_wr  (dat_wr),
        .busy     (init_busy),
        .casc_we  (casc_we)
    );

    // Trigger sensitivity per input: global mode, cascade inputs on a master
    always_comb level_sel = {NUM_IN{level_mode_q}} | (master_sel ? casc_q : '0);

    // Service strobe clears the polled request
    always_comb begin
        svc_clr = '0;
        if (poll_rd && found) svc_clr[lvl] = 1'b1;
    end

    irq_req_capture #(.N(NUM_IN)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_in   (irq_in),
        .level_sel(level_sel),
        .clr_all  (init_wr),
        .svc_clr  (svc_clr),
        .irr      (irr)
    );

    irq_prio_pick #(.N(NUM_IN)) u_pick (
        .req      (irr & ~imr_q),
        .isr      (isr_q),
        .found    (found),
        .lvl      (lvl),
        .top_found(top_found),
        .top_lvl  (top_lvl)
    );

    // Next in-service value: poll sets, end of interrupt clears
    always_comb begin
        isr_d = isr_q;
        if (poll_rd && found) isr_d[lvl] = 1'b1;
        if (spec_eoi) isr_d[bus_wdata[LVL_W-1:0]] = 1'b0;
        if (ns_eoi && top_found) isr_d[top_lvl] = 1'b0;
        if (init_wr) isr_d = '0;
    end

    // Control and status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr_q        <= '1;
            isr_q        <= '0;
            casc_q       <= '0;
            sel_isr_q    <= 1'b0;
            poll_q       <= 1'b0;
            level_mode_q <= 1'b0;
        end else begin
            isr_q <= isr_d;
            if (init_wr) begin
                imr_q        <= '0;
                sel_isr_q    <= 1'b0;
                poll_q       <= 1'b0;
                level_mode_q <= bus_wdata[3];
            end else begin
                if (dat_wr && !init_busy) imr_q <= bus_wdata;
                if (sel_wr && bus_wdata[1]) sel_isr_q <= bus_wdata[0];
                if (sel_wr) poll_q <= bus_wdata[2];
                else if (bus_rd && !bus_addr) poll_q <= 1'b0;
            end
            if (casc_we) casc_q <= bus_wdata;
        end
    end

    // Read mux and interrupt output
    always_comb begin
        if (bus_addr)      bus_rdata = imr_q;
        else if (poll_q)   bus_rdata = {found, 4'b0000, found ? lvl : LVL_W'(NUM_IN - 1)};
        else if (sel_isr_q) bus_rdata = isr_q;
        else               bus_rdata = irr;
        irq_out = found;
    end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
// Module: irq_prio_ctrl_chk
// Property checker bound to irq_prio_ctrl; observes ports and key state.
module irq_prio_ctrl_chk
    import irq_prio_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic              irq_out,
    input logic [NUM_IN-1:0] isr,
    input logic [NUM_IN-1:0] imr,
    input logic [NUM_IN-1:0] irr,
    input logic              poll_pend,
    input logic              init_busy
);
    AST_INT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((irr & ~imr) != '0)); // R6

    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[4]) |=> (isr == '0 && imr == '0)); // R2

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && !init_busy) |=> (imr == $past(bus_wdata))); // R4

    AST_POLL_MARKS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_addr && poll_pend && bus_rdata[7] && !bus_wr)
        |=> isr[$past(bus_rdata[LVL_W-1:0])]); // R8

    AST_SEOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[7:3] == 5'b01100 && !bus_rd)
        |=> !isr[$past(bus_wdata[LVL_W-1:0])]); // R9
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_out  (irq_out),
    .isr      (isr_q),
    .imr      (imr_q),
    .irr      (irr),
    .poll_pend(poll_q),
    .init_busy(init_busy)
);

// File: tb/tb_irq_prio_ctrl.sv
// Directed bench: master instance dut plus a slave for cascade tests.
module tb_irq_prio_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0, rd = 1'b0, addr = 1'b0;
    logic       dsel = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] m_in = '0, s_in = '0;
    logic [7:0] m_rdata, s_rdata;
    logic       m_out, s_out;
    int         n_chk = 0, n_err = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    irq_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .master_sel(1'b1),
        .bus_wr(wr && !dsel), .bus_rd(rd && !dsel), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(m_rdata),
        .irq_in({m_in[7:3], s_out, m_in[1:0]}), .irq_out(m_out)
    );

    irq_prio_ctrl u_slv (
        .clk(clk), .rst_n(rst_n), .master_sel(1'b0),
        .bus_wr(wr && dsel), .bus_rd(rd && dsel), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(s_rdata),
        .irq_in(s_in), .irq_out(s_out)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(input logic d, input logic a, input logic [7:0] v);
        dsel = d; addr = a; wdata = v; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input logic d, input logic a, output logic [7:0] v);
        dsel = d; addr = a; rd = 1'b1;
        #1 v = d ? s_rdata : m_rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic poll(input logic d, input logic [7:0] exp, input string req);
        logic [7:0] v;
        wreg(d, 1'b0, 8'h0C);
        rreg(d, 1'b0, v);
        chk(req, v, exp);
    endtask

    task automatic rd_isr(input logic d, input logic [7:0] exp, input string req);
        logic [7:0] v;
        wreg(d, 1'b0, 8'h0B);
        rreg(d, 1'b0, v);
        chk(req, v, exp);
    endtask

    task automatic rd_irr(input logic d, input logic [7:0] exp, input string req);
        logic [7:0] v;
        wreg(d, 1'b0, 8'h0A);
        rreg(d, 1'b0, v);
        chk(req, v, exp);
    endtask

    task automatic init_dev(input logic d, input logic [7:0] w1, input logic [7:0] base,
                            input logic [7:0] casc);
        wreg(d, 1'b0, w1);
        wreg(d, 1'b1, base);
        wreg(d, 1'b1, casc);
        wreg(d, 1'b1, 8'h01);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rreg(1'b0, 1'b1, v); chk("R1 mask", v, 8'hFF);
        rreg(1'b0, 1'b0, v); chk("R1 request reg", v, 8'h00);
        chk("R1 irq_out", {7'd0, m_out}, 8'h00);
    endtask

    task automatic t_init;
        logic [7:0] v;
        init_dev(1'b0, 8'h11, 8'h20, 8'h04);
        rreg(1'b0, 1'b1, v); chk("R2 words consumed, mask cleared", v, 8'h00);
        wreg(1'b0, 1'b1, 8'hA5);
        rreg(1'b0, 1'b1, v); chk("R4 mask load", v, 8'hA5);
        wreg(1'b0, 1'b1, 8'hFF);
        init_dev(1'b1, 8'h11, 8'h28, 8'h02);
        rreg(1'b1, 1'b1, v); chk("R2 slave mask cleared", v, 8'h00);
    endtask

    task automatic t_short_init;
        logic [7:0] v;
        wreg(1'b1, 1'b0, 8'h13);
        wreg(1'b1, 1'b1, 8'h30);
        wreg(1'b1, 1'b1, 8'h01);
        rreg(1'b1, 1'b1, v); chk("R3 two words consumed", v, 8'h00);
        wreg(1'b1, 1'b1, 8'h5A);
        rreg(1'b1, 1'b1, v); chk("R3 third write is mask", v, 8'h5A);
        init_dev(1'b1, 8'h11, 8'h28, 8'h02);
        wreg(1'b1, 1'b1, 8'hFF);
    endtask

    task automatic t_mask;
        m_in[5] = 1'b1; tick(2);
        chk("R4 masked no irq", {7'd0, m_out}, 8'h00);
        rd_irr(1'b0, 8'h20, "R4 masked request recorded");
        wreg(1'b0, 1'b1, 8'hDF); tick(1);
        chk("R4 unmasked irq", {7'd0, m_out}, 8'h01);
        m_in[5] = 1'b0; tick(1);
        wreg(1'b0, 1'b1, 8'h00);
    endtask

    task automatic t_priority;
        m_in[5] = 1'b1; m_in[3] = 1'b1; tick(2);
        poll(1'b0, 8'h83, "R8 poll picks level 3");
        rd_isr(1'b0, 8'h08, "R8 in-service set");
        chk("R6 lower blocked by in-service", {7'd0, m_out}, 8'h00);
        poll(1'b0, 8'h07, "R8 nothing eligible");
        wreg(1'b0, 1'b0, 8'h63);
        rd_isr(1'b0, 8'h00, "R9 specific EOI");
        chk("R6 irq after release", {7'd0, m_out}, 8'h01);
        poll(1'b0, 8'h85, "R8 poll picks level 5");
        rd_irr(1'b0, 8'h00, "R5 edge held high no re-request");
        m_in[1] = 1'b1; tick(2);
        chk("R6 nesting more urgent", {7'd0, m_out}, 8'h01);
        poll(1'b0, 8'h81, "R8 poll picks level 1");
        rd_isr(1'b0, 8'h22, "R8 nested in-service");
        wreg(1'b0, 1'b0, 8'h20);
        rd_isr(1'b0, 8'h20, "R10 non-specific clears top");
        wreg(1'b0, 1'b0, 8'h20);
        rd_isr(1'b0, 8'h00, "R10 non-specific second");
        m_in = '0; tick(2);
        rd_irr(1'b0, 8'h00, "R7 request reg readback");
    endtask

    task automatic t_level;
        init_dev(1'b1, 8'h19, 8'h28, 8'h02);
        s_in[4] = 1'b1; tick(2);
        poll(1'b1, 8'h84, "R8 slave poll level 4");
        wreg(1'b1, 1'b0, 8'h64); tick(1);
        rd_irr(1'b1, 8'h10, "R5 level mode re-request");
        chk("R5 level irq again", {7'd0, s_out}, 8'h01);
        s_in[4] = 1'b0; tick(2);
        rd_irr(1'b1, 8'h00, "R5 level follows input");
        init_dev(1'b1, 8'h11, 8'h28, 8'h02);
    endtask

    task automatic t_spurious;
        m_in[7] = 1'b1; tick(2);
        chk("R11 level 7 raises irq", {7'd0, m_out}, 8'h01);
        m_in[7] = 1'b0; tick(2);
        poll(1'b0, 8'h07, "R11 spurious poll");
        rd_isr(1'b0, 8'h00, "R11 in-service 7 clear");
    endtask

    task automatic t_cascade;
        s_in[6] = 1'b1; tick(3);
        chk("R12 slave raises master", {7'd0, m_out}, 8'h01);
        poll(1'b0, 8'h82, "R12 master poll cascade");
        wreg(1'b0, 1'b0, 8'h62); tick(1);
        chk("R12 master re-raised by pending slave", {7'd0, m_out}, 8'h01);
        poll(1'b0, 8'h82, "R12 master poll again");
        poll(1'b1, 8'h86, "R12 slave poll level 6");
        tick(1);
        chk("R12 master quiet after slave service", {7'd0, m_out}, 8'h00);
        rd_isr(1'b1, 8'h40, "R12 slave in-service");
        wreg(1'b1, 1'b0, 8'h66);
        wreg(1'b0, 1'b0, 8'h62);
        rd_isr(1'b0, 8'h00, "R9 master released");
        s_in = '0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_init();
        t_short_init();
        t_mask();
        t_priority();
        t_level();
        t_spurious();
        t_cascade();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule